// File: doc/BRIEF.md
# E1 Sa-Bit Data Link Port

This block reaches the five national-use Sa bits that an E1 stream carries in timeslot 0 of every frame that lacks the frame alignment word. Together these bits form the performance-monitoring data link. The framer in front of the block supplies, for every bit clock, a timeslot-0 flag, a flag for frames that hold the alignment word, and the bit position within the timeslot. The block uses these to find the Sa positions.

On the receive side, the block sends every Sa bit out on a serial link output and gathers the five bits into a parallel register. It also drives a link clock that pulses only on the Sa positions set in a per-bit receive mask, so an external device can pick up any subset of the Sa bits. On the transmit side, the block rebuilds timeslot 0 on its way out. It replaces each Sa position with the matching bit of an internal transmit register, or with the serial link input when pin sourcing is enabled and that position's mask bit is set. All other bits pass through with one cycle of delay.

Top module: `e1_sa_link`

## Requirements
- R1: While reset is asserted, and after it is released, all outputs are 0 until the first bit has been processed.
- R2: Each bit time at an Sa position (timeslot 0, frame without the alignment word, `bit_pos` 3 to 7 for Sa4 to Sa8) shows the received bit on `rx_link_out` one clock later, whatever the receive mask holds.
- R3: `rx_link_clk` is 1 one clock after an Sa position whose `rx_clk_mask` bit is 1, where mask bit k belongs to `bit_pos` 3+k. At every other time it is 0.
- R4: `rx_sa_q` takes all five Sa bits of a frame one clock after the Sa8 position (`bit_pos` 7), with bit k holding the bit received at `bit_pos` 3+k. At all other times it holds its value.
- R5: Frames that carry the alignment word, and bits outside timeslot 0, leave `rx_sa_q` unchanged and give 0 on `rx_link_out` and `rx_link_clk` one clock later.
- R6: When `tx_ext_en` is 0, each Sa position of `tx_bit_out` (one clock later) carries `tx_sa_reg` bit k for `bit_pos` 3+k, whatever `tx_ext_mask` holds.
- R7: When `tx_ext_en` is 1 and `tx_ext_mask` bit k is 1, the Sa position `bit_pos` 3+k carries the value of `tx_link_in` sampled in that same bit time. Positions whose mask bit is 0 still use `tx_sa_reg`.
- R8: Bits outside the Sa positions, including all bits of frames that carry the alignment word and of other timeslots, appear on `tx_bit_out` unchanged one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one stream bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_ts0 | input | 1 | Current bit belongs to timeslot 0 |
| in_fas | input | 1 | Current frame carries the frame alignment word |
| bit_pos | input | 3 | Bit index 0..7 within the timeslot |
| rx_bit | input | 1 | Received stream bit |
| rx_clk_mask | input | 5 | Per-Sa enable for link clock pulses |
| rx_sa_q | output | 5 | Sa bits of the last complete frame |
| rx_link_out | output | 1 | Serial copy of every received Sa bit |
| rx_link_clk | output | 1 | Gated link clock for the selected Sa bits |
| tx_bit_in | input | 1 | Outgoing stream bit before Sa insertion |
| tx_sa_reg | input | 5 | Internal transmit Sa values |
| tx_ext_en | input | 1 | Global enable for pin sourcing |
| tx_ext_mask | input | 5 | Per-Sa choice of the link pin as source |
| tx_link_in | input | 1 | Serial transmit link input |
| tx_bit_out | output | 1 | Outgoing stream bit after Sa insertion |

## Verification
A bad position decode shows up within one clock. The link data, the link clock or the transmitted bit then lands on the wrong bit slot, or appears in a frame with the alignment word. A corrupted staging bit stays hidden until the Sa8 position and then shows in `rx_sa_q` one clock later. So every receive frame ends with a comparison of the whole register. The bench runs frames with and without the alignment word, several receive masks, and every mix of transmit sources. It drives an inverted value on the link pin outside the sampled slots, so that a sample taken at the wrong time is caught.

// File: rtl/e1_sa_pkg.sv
package e1_sa_pkg;
  localparam int SA_COUNT_DEF = 5;
  localparam int SA_FIRST_DEF = 3;
  localparam int POS_W_DEF    = 3;

  function automatic logic sel_pick(input logic [SA_COUNT_DEF-1:0] vec,
                                    input logic [SA_COUNT_DEF-1:0] sel);
    return |(vec & sel);
  endfunction
endpackage

// File: rtl/e1_sa_slot_dec.sv
module e1_sa_slot_dec #(
  parameter int SA_COUNT = 5,
  parameter int SA_FIRST = 3,
  parameter int POS_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_ts0,
  input  logic                in_fas,
  input  logic [POS_W-1:0]    bit_pos,
  output logic [SA_COUNT-1:0] sa_sel,
  output logic                sa_hit,
  output logic                sa_last
);
  logic frame_ok;
  assign frame_ok = in_ts0 & ~in_fas;

  for (genvar k = 0; k < SA_COUNT; k++) begin : g_slot
    assign sa_sel[k] = frame_ok && (bit_pos == POS_W'(SA_FIRST + k));
  end

  assign sa_hit  = |sa_sel;
  assign sa_last = sa_sel[SA_COUNT-1];

  // R2: at most one Sa slot decoded per bit time
  a_r2_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sa_sel));
  // R5: no slot in frames carrying the alignment word
  a_r5_fas_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fas || !in_ts0) |-> !sa_hit);
endmodule

// File: rtl/e1_sa_rx.sv
module e1_sa_rx #(
  parameter int SA_COUNT = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SA_COUNT-1:0] sa_sel,
  input  logic                sa_hit,
  input  logic                sa_last,
  input  logic                rx_bit,
  input  logic [SA_COUNT-1:0] rx_clk_mask,
  output logic [SA_COUNT-1:0] rx_sa_q,
  output logic                rx_link_out,
  output logic                rx_link_clk
);
  logic [SA_COUNT-1:0] stage_q, stage_d;
  logic [SA_COUNT-1:0] saq_d;
  logic                lo_d, lclk_d;
  logic                saq_en;

  for (genvar k = 0; k < SA_COUNT; k++) begin : g_stage
    assign stage_d[k] = sa_sel[k] ? rx_bit : stage_q[k];
  end

  always_comb begin
    saq_en = sa_last;
    saq_d  = stage_d;
    lo_d   = sa_hit & rx_bit;
    lclk_d = |(rx_clk_mask & sa_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q     <= '0;
      rx_sa_q     <= '0;
      rx_link_out <= 1'b0;
      rx_link_clk <= 1'b0;
    end else begin
      if (sa_hit) stage_q <= stage_d;
      if (saq_en) rx_sa_q <= saq_d;
      rx_link_out <= lo_d;
      rx_link_clk <= lclk_d;
    end
  end

  // R2: serial link follows the received bit at every Sa slot
  a_r2_link_copy: assert property (@(posedge clk) disable iff (!rst_n)
    sa_hit |=> (rx_link_out == $past(rx_bit)));
  // R3: a masked-off slot never pulses the link clock
  a_r3_clk_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (sa_hit && ((rx_clk_mask & sa_sel) == '0)) |=> !rx_link_clk);
  // R5: no link clock outside Sa slots
  a_r5_clk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sa_hit |=> !rx_link_clk && !rx_link_out);
  // R4: parallel register moves only after the last slot
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sa_last |=> $stable(rx_sa_q));
  // R4: last slot value lands in the top bit
  a_r4_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
    sa_last |=> (rx_sa_q[SA_COUNT-1] == $past(rx_bit)));
endmodule

// File: rtl/e1_sa_tx.sv
module e1_sa_tx #(
  parameter int SA_COUNT = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SA_COUNT-1:0] sa_sel,
  input  logic                sa_hit,
  input  logic                tx_bit_in,
  input  logic [SA_COUNT-1:0] tx_sa_reg,
  input  logic                tx_ext_en,
  input  logic [SA_COUNT-1:0] tx_ext_mask,
  input  logic                tx_link_in,
  output logic                tx_bit_out
);
  logic use_pin;
  logic reg_bit;
  logic sa_bit;
  logic out_d;

  always_comb begin
    use_pin = tx_ext_en & (|(tx_ext_mask & sa_sel));
    reg_bit = |(tx_sa_reg & sa_sel);
    sa_bit  = use_pin ? tx_link_in : reg_bit;
    out_d   = sa_hit ? sa_bit : tx_bit_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_bit_out <= 1'b0;
    else        tx_bit_out <= out_d;
  end

  // R8: non-Sa bits pass unchanged
  a_r8_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !sa_hit |=> (tx_bit_out == $past(tx_bit_in)));
  // R6: global enable low always selects the register
  a_r6_reg_src: assert property (@(posedge clk) disable iff (!rst_n)
    (sa_hit && !tx_ext_en) |=> (tx_bit_out == $past(reg_bit)));
  // R7: enabled pin slots carry the link input
  a_r7_pin_src: assert property (@(posedge clk) disable iff (!rst_n)
    (sa_hit && tx_ext_en && ((tx_ext_mask & sa_sel) != '0))
      |=> (tx_bit_out == $past(tx_link_in)));
endmodule

// File: rtl/e1_sa_link.sv
module e1_sa_link
  import e1_sa_pkg::*;
#(
  parameter int SA_COUNT = SA_COUNT_DEF,
  parameter int SA_FIRST = SA_FIRST_DEF,
  parameter int POS_W    = POS_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_ts0,
  input  logic                in_fas,
  input  logic [POS_W-1:0]    bit_pos,
  input  logic                rx_bit,
  input  logic [SA_COUNT-1:0] rx_clk_mask,
  output logic [SA_COUNT-1:0] rx_sa_q,
  output logic                rx_link_out,
  output logic                rx_link_clk,
  input  logic                tx_bit_in,
  input  logic [SA_COUNT-1:0] tx_sa_reg,
  input  logic                tx_ext_en,
  input  logic [SA_COUNT-1:0] tx_ext_mask,
  input  logic                tx_link_in,
  output logic                tx_bit_out
);
  logic [SA_COUNT-1:0] sa_sel;
  logic                sa_hit;
  logic                sa_last;

  e1_sa_slot_dec #(.SA_COUNT(SA_COUNT), .SA_FIRST(SA_FIRST), .POS_W(POS_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_ts0  (in_ts0),
    .in_fas  (in_fas),
    .bit_pos (bit_pos),
    .sa_sel  (sa_sel),
    .sa_hit  (sa_hit),
    .sa_last (sa_last)
  );

  e1_sa_rx #(.SA_COUNT(SA_COUNT)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .sa_sel      (sa_sel),
    .sa_hit      (sa_hit),
    .sa_last     (sa_last),
    .rx_bit      (rx_bit),
    .rx_clk_mask (rx_clk_mask),
    .rx_sa_q     (rx_sa_q),
    .rx_link_out (rx_link_out),
    .rx_link_clk (rx_link_clk)
  );

  e1_sa_tx #(.SA_COUNT(SA_COUNT)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .sa_sel      (sa_sel),
    .sa_hit      (sa_hit),
    .tx_bit_in   (tx_bit_in),
    .tx_sa_reg   (tx_sa_reg),
    .tx_ext_en   (tx_ext_en),
    .tx_ext_mask (tx_ext_mask),
    .tx_link_in  (tx_link_in),
    .tx_bit_out  (tx_bit_out)
  );

  // R1: outputs start cleared after reset
  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> (rx_sa_q == '0) && !rx_link_clk && !rx_link_out && !tx_bit_out);
endmodule

// File: tb/sim_e1_sa_link.sv
`timescale 1ns/1ps
module sim_e1_sa_link;
  localparam int LIMIT_CYC = 200000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_ts0, in_fas, rx_bit, tx_bit_in, tx_ext_en, tx_link_in;
  logic [2:0] bit_pos;
  logic [4:0] rx_clk_mask, tx_sa_reg, tx_ext_mask;
  logic [4:0] rx_sa_q;
  logic       rx_link_out, rx_link_clk, tx_bit_out;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic       lo;
    logic       lclk;
    logic [4:0] saq;
    logic       tx;
    string      t_lo;
    string      t_clk;
    string      t_tx;
  } exp_t;

  exp_t sb[$];
  logic [4:0] m_stage = '0;
  logic [4:0] m_saq   = '0;

  always #2.5 clk = ~clk;

  e1_sa_link u0 (
    .clk(clk), .rst_n(rst_n), .in_ts0(in_ts0), .in_fas(in_fas), .bit_pos(bit_pos),
    .rx_bit(rx_bit), .rx_clk_mask(rx_clk_mask), .rx_sa_q(rx_sa_q),
    .rx_link_out(rx_link_out), .rx_link_clk(rx_link_clk), .tx_bit_in(tx_bit_in),
    .tx_sa_reg(tx_sa_reg), .tx_ext_en(tx_ext_en), .tx_ext_mask(tx_ext_mask),
    .tx_link_in(tx_link_in), .tx_bit_out(tx_bit_out)
  );

  task automatic chk(string tag, string what, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // one bit time: drive at negedge, push expectation
  task automatic step(logic ts0, logic fas, logic [2:0] pos, logic rb, logic tb, logic lk);
    exp_t e;
    logic hit;
    int   k;
    @(negedge clk);
    in_ts0 = ts0; in_fas = fas; bit_pos = pos;
    rx_bit = rb; tx_bit_in = tb; tx_link_in = lk;
    hit = ts0 && !fas && pos >= 3;
    k = int'(pos) - 3;
    e.lo   = hit ? rb : 1'b0;
    e.lclk = hit ? rx_clk_mask[k] : 1'b0;
    if (hit) m_stage[k] = rb;
    if (hit && k == 4) m_saq = m_stage;
    e.saq  = m_saq;
    if (hit) e.tx = (tx_ext_en && tx_ext_mask[k]) ? lk : tx_sa_reg[k];
    else     e.tx = tb;
    e.t_lo  = hit ? "R2" : "R5";
    e.t_clk = hit ? "R3" : "R5";
    e.t_tx  = hit ? ((tx_ext_en && tx_ext_mask[k]) ? "R7" : "R6") : "R8";
    sb.push_back(e);
  endtask

  // monitor: outputs one clock after the inputs
  always @(posedge clk) begin
    #1;
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.t_lo,  "rx_link_out", {4'b0, rx_link_out}, {4'b0, e.lo});
      chk(e.t_clk, "rx_link_clk", {4'b0, rx_link_clk}, {4'b0, e.lclk});
      chk("R4",    "rx_sa_q",     rx_sa_q, e.saq);
      chk(e.t_tx,  "tx_bit_out",  {4'b0, tx_bit_out}, {4'b0, e.tx});
    end
  end

  // timeslot 0 then timeslot 1; link pin inverted outside its slot
  task automatic frame(logic fas, logic [4:0] rxs, logic [4:0] lks, logic [7:0] pat);
    for (int b = 0; b < 8; b++) begin
      logic rb, lk;
      rb = (b >= 3) ? rxs[b-3] : pat[7-b];
      lk = (b >= 3) ? lks[b-3] : ~pat[b];
      step(1'b1, fas, 3'(b), rb, pat[b], lk);
      // second half-step: nothing extra
    end
    for (int b = 0; b < 8; b++) begin
      step(1'b0, fas, 3'(b), pat[b], ~pat[b], pat[7-b]);
    end
  endtask

  task automatic ctl(logic [4:0] rm, logic [4:0] treg, logic en, logic [4:0] tm);
    @(negedge clk);
    rx_clk_mask = rm; tx_sa_reg = treg; tx_ext_en = en; tx_ext_mask = tm;
  endtask

  initial begin
    #(LIMIT_CYC * 5.0);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_ts0 = 0; in_fas = 0; bit_pos = '0; rx_bit = 0; tx_bit_in = 0;
    tx_link_in = 0; tx_ext_en = 0; rx_clk_mask = '0; tx_sa_reg = '0; tx_ext_mask = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "rx_sa_q",     rx_sa_q, 5'b0);
    chk("R1", "rx_link_out", {4'b0, rx_link_out}, 5'b0);
    chk("R1", "rx_link_clk", {4'b0, rx_link_clk}, 5'b0);
    chk("R1", "tx_bit_out",  {4'b0, tx_bit_out}, 5'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "rx_sa_q after release", rx_sa_q, 5'b0);
    chk("R1", "tx_bit_out after release", {4'b0, tx_bit_out}, 5'b0);

    // R2 R3 R4 R6: register source, partial clock mask
    ctl(5'b10101, 5'b10110, 1'b0, 5'b11111);
    frame(1'b0, 5'b11001, 5'b00110, 8'hA5);
    // R5 R8: alignment frame leaves everything alone
    frame(1'b1, 5'b00110, 5'b11111, 8'h3C);
    // R7: mixed pin and register sources, full clock mask
    ctl(5'b11111, 5'b00000, 1'b1, 5'b01101);
    frame(1'b0, 5'b10011, 5'b11011, 8'h5A);
    // R7: all positions from the pin
    ctl(5'b00000, 5'b11111, 1'b1, 5'b11111);
    frame(1'b0, 5'b01110, 5'b01010, 8'hC3);
    // R6: enable low overrides mask, R3 single-bit mask at Sa8
    ctl(5'b10000, 5'b01001, 1'b0, 5'b11111);
    frame(1'b0, 5'b11111, 5'b00000, 8'h0F);
    frame(1'b1, 5'b00000, 5'b10101, 8'hF0);
    for (int i = 0; i < 6; i++) begin
      ctl(5'(i * 7 + 3), 5'(i * 11), i[0], 5'(i * 13 + 1));
      frame(i[1], 5'(i * 5 + 2), 5'(i * 9 + 4), 8'(i * 37 + 17));
    end
    repeat (3) @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule